// File: doc/BRIEF.md
# Near-Memory Accelerator Issue Throttle

This block sits in one memory channel where processing elements placed beside the DRAM share ranks with the host memory controller. Each rank has one accelerator request slot. Every cycle the block decides which accelerator command, if any, may go onto the rank it targets. The host always comes first. An accelerator command can only use a rank that the host is not driving in that cycle, and an accelerator row command (activate or precharge) gives way to a waiting host command on the same bank.

Accelerator writes cause read/write turnarounds that slow the host. The block can hold them back in one of two ways. In random mode, a weighted draw from a 16-bit LFSR is compared with a programmable probability. In prediction mode, writes to a rank are held while the oldest request in the host queue is a read to that rank. The per-rank prediction flag is registered, so it can be sent to the memory side one cycle before the host command. A held request is not buffered. Its slot simply stays asserted until it is granted. Accelerator reads are never throttled.

Top module: `aig_issue_gate`

## Requirements
- R1: `grant` is one-hot or zero, and a bit is set only for a rank whose `acc_valid` bit is set.
- R2: No grant goes to a rank whose `host_busy` bit is set in that cycle.
- R3: An accelerator row command (`acc_row`=1) is not granted while `host_pend_valid` is set and `host_pend_rank` and `host_pend_bank` equal that request's rank and bank. Column commands (`acc_row`=0) to the same bank are not affected.
- R4: The `mode` encoding is 2'b00 off, 2'b01 random, 2'b10 prediction. The code 2'b11 behaves as off. In off mode, writes are granted exactly like reads.
- R5: In random mode, a write is granted only when the current LFSR draw is below `wr_prob`. With `wr_prob`=0 no write is ever granted.
- R6: In random mode with `wr_prob`=16'hFFFF, a continuously requesting write is refused at most once per 65535 cycles. With `wr_prob`=16'h8000, roughly half the cycles grant.
- R7: In prediction mode, `inhibit[r]` is set one clock after a cycle in which `hq_valid`=1, `hq_read`=1 and `hq_rank`=r. While `inhibit[r]` is set, no write to rank r is granted. Other ranks are unaffected.
- R8: `inhibit` is all zero one clock after any cycle in which the head is not a valid read or the mode is not prediction.
- R9: Reads (`acc_write`=0) are granted regardless of `wr_prob` and `inhibit`.
- R10: Eligible ranks are served round-robin. After reset the search starts at rank 0, and with every rank requesting, grants go 0,1,2,3,0,...
- R11: A held request is not dropped. The same request is granted in the first cycle its blocking condition is gone.
- R12: While reset is asserted, `inhibit` is zero. With no request, `grant` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | Throttle mode (R4 encoding) |
| wr_prob | input | 16 | Write-issue probability threshold |
| host_busy | input | NR | Per-rank host use in this cycle |
| host_pend_valid | input | 1 | A host command waits for a bank |
| host_pend_rank | input | RW | Rank of the waiting host command |
| host_pend_bank | input | BANK_W | Bank of the waiting host command |
| hq_valid | input | 1 | Host queue head is valid |
| hq_rank | input | RW | Rank of the host queue head |
| hq_read | input | 1 | Host queue head is a read |
| acc_valid | input | NR | Per-rank accelerator request |
| acc_write | input | NR | Request is a write |
| acc_row | input | NR | Request is a row command (ACT/PRE) |
| acc_bank | input | NR*BANK_W | Per-rank target bank, rank r at bits r*BANK_W |
| grant | output | NR | One-hot issue grant |
| inhibit | output | NR | Registered per-rank write inhibit |

## Verification
The bench uses the defaults of four ranks and three bank bits. Four ranks are enough to see a full round-robin rotation, and they let one rank be inhibited while its neighbours are still granted. Three bank bits allow a matching and a non-matching bank on the same rank for the row-command hold. The 16-bit draw makes the two extreme probabilities exact: zero blocks every write, and all-ones refuses at most once in a 200-cycle run. A 400-cycle run at half weight shows that the middle of the range gates writes at a rate that is neither extreme.

// File: rtl/aig_pkg.sv
package aig_pkg;
  typedef enum logic [1:0] {
    THR_OFF  = 2'b00,
    THR_RAND = 2'b01,
    THR_PRED = 2'b10
  } thr_mode_e;
endpackage

// File: rtl/aig_lfsr.sv
module aig_lfsr #(
  parameter int          W    = 16,
  parameter logic [W-1:0] TAPS = 16'hB400,
  parameter logic [W-1:0] SEED = 16'hACE1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  output logic [W-1:0] state
);
  logic [W-1:0] state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (en) state_d = (state_q >> 1) ^ (state_q[0] ? TAPS : '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SEED;
    else        state_q <= state_d;
  end

  assign state = state_q;
endmodule

// File: rtl/aig_rr_arb.sv
module aig_rr_arb #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt
);
  localparam int PW = (N > 1) ? $clog2(N) : 1;

  logic [PW-1:0] ptr_q, ptr_d;
  logic          found;

  // search starts one past the last granted slot
  always_comb begin
    gnt   = '0;
    found = 1'b0;
    for (int off = 1; off <= N; off++) begin
      int idx;
      idx = int'(ptr_q) + off;
      if (idx >= N) idx = idx - N;
      if (!found && req[idx]) begin
        gnt[idx] = 1'b1;
        found    = 1'b1;
      end
    end
  end

  always_comb begin
    ptr_d = ptr_q;
    for (int i = 0; i < N; i++) begin
      if (gnt[i]) ptr_d = PW'(i);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ptr_q <= PW'(N - 1);
    else if (found) ptr_q <= ptr_d;
  end
endmodule

// File: rtl/aig_rank_gate.sv
module aig_rank_gate (
  input  logic       req_valid,
  input  logic       req_write,
  input  logic       req_row,
  input  logic       host_busy,
  input  logic       bank_clash,
  input  logic [1:0] mode,
  input  logic       draw_pass,
  input  logic       inhibit,
  output logic       eligible
);
  import aig_pkg::*;

  logic wr_ok;

  always_comb begin
    unique case (mode)
      THR_RAND: wr_ok = draw_pass;
      THR_PRED: wr_ok = !inhibit;
      default:  wr_ok = 1'b1;
    endcase
  end

  assign eligible = req_valid && !host_busy && !(req_row && bank_clash)
                    && (!req_write || wr_ok);
endmodule

// File: rtl/aig_issue_gate.sv
module aig_issue_gate #(
  parameter int NR     = 4,
  parameter int BANK_W = 3,
  parameter int PROB_W = 16,
  localparam int RW    = (NR > 1) ? $clog2(NR) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           mode,
  input  logic [PROB_W-1:0]    wr_prob,
  input  logic [NR-1:0]        host_busy,
  input  logic                 host_pend_valid,
  input  logic [RW-1:0]        host_pend_rank,
  input  logic [BANK_W-1:0]    host_pend_bank,
  input  logic                 hq_valid,
  input  logic [RW-1:0]        hq_rank,
  input  logic                 hq_read,
  input  logic [NR-1:0]        acc_valid,
  input  logic [NR-1:0]        acc_write,
  input  logic [NR-1:0]        acc_row,
  input  logic [NR*BANK_W-1:0] acc_bank,
  output logic [NR-1:0]        grant,
  output logic [NR-1:0]        inhibit
);
  import aig_pkg::*;

  logic [PROB_W-1:0] draw;
  logic              draw_pass;
  logic              draw_en;
  logic [NR-1:0]     inh_q, inh_d;
  logic [NR-1:0]     elig;

  assign draw_en = (mode == THR_RAND);

  aig_lfsr #(.W(PROB_W)) u_lfsr (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (draw_en),
    .state (draw)
  );

  assign draw_pass = (draw < wr_prob);

  // next-rank prediction, registered so it leads the host command
  always_comb begin
    inh_d = '0;
    if (mode == THR_PRED && hq_valid && hq_read) inh_d[hq_rank] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) inh_q <= '0;
    else        inh_q <= inh_d;
  end

  for (genvar g = 0; g < NR; g++) begin : g_rank
    localparam logic [RW-1:0] RID = RW'(g);
    logic clash;
    assign clash = host_pend_valid && (host_pend_rank == RID)
                   && (host_pend_bank == acc_bank[g*BANK_W +: BANK_W]);
    aig_rank_gate u_gate (
      .req_valid  (acc_valid[g]),
      .req_write  (acc_write[g]),
      .req_row    (acc_row[g]),
      .host_busy  (host_busy[g]),
      .bank_clash (clash),
      .mode       (mode),
      .draw_pass  (draw_pass),
      .inhibit    (inh_q[g]),
      .eligible   (elig[g])
    );
  end

  aig_rr_arb #(.N(NR)) u_arb (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (elig),
    .gnt   (grant)
  );

  assign inhibit = inh_q;
endmodule

// File: rtl/aig_issue_gate_chk.sv
module aig_issue_gate_chk #(
  parameter int NR     = 4,
  parameter int BANK_W = 3,
  parameter int PROB_W = 16,
  localparam int RW    = (NR > 1) ? $clog2(NR) : 1
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [1:0]           mode,
  input logic [PROB_W-1:0]    wr_prob,
  input logic [NR-1:0]        host_busy,
  input logic                 host_pend_valid,
  input logic [RW-1:0]        host_pend_rank,
  input logic [BANK_W-1:0]    host_pend_bank,
  input logic                 hq_valid,
  input logic [RW-1:0]        hq_rank,
  input logic                 hq_read,
  input logic [NR-1:0]        acc_valid,
  input logic [NR-1:0]        acc_write,
  input logic [NR-1:0]        acc_row,
  input logic [NR*BANK_W-1:0] acc_bank,
  input logic [NR-1:0]        grant,
  input logic [NR-1:0]        inhibit
);
  logic [NR-1:0] row_hold;
  always_comb begin
    row_hold = '0;
    for (int r = 0; r < NR; r++) begin
      if (host_pend_valid && int'(host_pend_rank) == r && acc_row[r]
          && acc_bank[r*BANK_W +: BANK_W] == host_pend_bank)
        row_hold[r] = 1'b1;
    end
  end

  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(grant)); // R1
  AST_GRANT_REQ: assert property (@(posedge clk) disable iff (!rst_n) (grant & ~acc_valid) == '0); // R1
  AST_HOST_BUSY: assert property (@(posedge clk) disable iff (!rst_n) (grant & host_busy) == '0); // R2
  AST_ROW_BANK: assert property (@(posedge clk) disable iff (!rst_n) (grant & row_hold) == '0); // R3
  AST_PROB_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (mode == 2'b01 && wr_prob == '0) |-> (grant & acc_write) == '0); // R5
  AST_INHIBIT_WR: assert property (@(posedge clk) disable iff (!rst_n) (mode == 2'b10) |-> (grant & acc_write & inhibit) == '0); // R7
  AST_INHIBIT_SET: assert property (@(posedge clk) disable iff (!rst_n) (mode == 2'b10 && hq_valid && hq_read) |=> ($countones(inhibit) == 1 && inhibit[$past(hq_rank)])); // R7
  AST_INHIBIT_CLR: assert property (@(posedge clk) disable iff (!rst_n) !(mode == 2'b10 && hq_valid && hq_read) |=> inhibit == '0); // R8
endmodule

bind aig_issue_gate aig_issue_gate_chk #(.NR(NR), .BANK_W(BANK_W), .PROB_W(PROB_W)) u_chk (.*);

// File: tb/tb_aig_issue_gate.sv
module tb_aig_issue_gate;
  localparam int CLK_PERIOD = 10;
  localparam int NR = 4;
  localparam int BANK_W = 3;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [1:0]        mode;
  logic [15:0]       wr_prob;
  logic [NR-1:0]     host_busy;
  logic              host_pend_valid;
  logic [1:0]        host_pend_rank;
  logic [BANK_W-1:0] host_pend_bank;
  logic              hq_valid;
  logic [1:0]        hq_rank;
  logic              hq_read;
  logic [NR-1:0]     acc_valid, acc_write, acc_row;
  logic [NR*BANK_W-1:0] acc_bank;
  logic [NR-1:0]     grant, inhibit;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  aig_issue_gate #(.NR(NR), .BANK_W(BANK_W)) dut (.*);

  task automatic check(string req, int got, int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  // next sampling point: one unit after the falling edge
  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic idle_inputs();
    mode = 2'b00; wr_prob = '0; host_busy = '0;
    host_pend_valid = 1'b0; host_pend_rank = '0; host_pend_bank = '0;
    hq_valid = 1'b0; hq_rank = '0; hq_read = 1'b0;
    acc_valid = '0; acc_write = '0; acc_row = '0; acc_bank = '0;
  endtask

  task automatic t_reset();
    idle_inputs();
    rst_n = 1'b0;
    #(CLK_PERIOD*3);
    check("R12 inhibit in reset", int'(inhibit), 0);
    check("R12 grant idle", int'(grant), 0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_round_robin();
    @(negedge clk);
    acc_valid = 4'hF;
    #1;
    for (int i = 0; i < 8; i++) begin
      check("R10 rotation", int'(grant), 1 << (i % 4));
      check("R1 one-hot", $countones(grant), 1);
      step();
    end
    acc_valid = '0;
  endtask

  task automatic t_busy();
    @(negedge clk);
    acc_valid = 4'b0010; host_busy = 4'b0010;
    #1;
    check("R2 busy rank held", int'(grant), 0);
    step();
    check("R2 still held", int'(grant), 0);
    host_busy = 4'b0001;
    #1;
    check("R11 held request granted when rank frees", int'(grant), 2);
    acc_valid = '0; host_busy = '0;
  endtask

  task automatic t_row_bank();
    @(negedge clk);
    acc_valid = 4'b0100; acc_row = 4'b0100;
    acc_bank[2*BANK_W +: BANK_W] = 3'd5;
    host_pend_valid = 1'b1; host_pend_rank = 2'd2; host_pend_bank = 3'd5;
    #1;
    check("R3 row cmd held on same bank", int'(grant), 0);
    acc_row = '0;
    #1;
    check("R3 column cmd same bank passes", int'(grant), 4);
    acc_row = 4'b0100; host_pend_bank = 3'd4;
    #1;
    check("R3 row cmd other bank passes", int'(grant), 4);
    host_pend_bank = 3'd5; host_pend_rank = 2'd1;
    #1;
    check("R3 row cmd other rank passes", int'(grant), 4);
    acc_valid = '0; acc_row = '0; host_pend_valid = 1'b0;
  endtask

  task automatic t_off_modes();
    @(negedge clk);
    mode = 2'b00; wr_prob = 16'h0000;
    acc_valid = 4'b0001; acc_write = 4'b0001;
    #1;
    check("R4 off mode grants write", int'(grant), 1);
    mode = 2'b11;
    #1;
    check("R4 code 11 behaves as off", int'(grant), 1);
    acc_valid = '0; acc_write = '0; mode = 2'b00;
  endtask

  task automatic t_random();
    int cnt;
    @(negedge clk);
    mode = 2'b01; wr_prob = 16'h0000;
    acc_valid = 4'b0001; acc_write = 4'b0001;
    #1;
    cnt = 0;
    for (int i = 0; i < 100; i++) begin
      if (grant[0]) cnt++;
      step();
    end
    check("R5 prob zero blocks writes", cnt, 0);
    acc_write = '0;
    #1;
    cnt = 0;
    for (int i = 0; i < 100; i++) begin
      if (grant[0]) cnt++;
      step();
    end
    check("R9 reads free in random mode", cnt, 100);
    acc_write = 4'b0001; wr_prob = 16'hFFFF;
    #1;
    cnt = 0;
    for (int i = 0; i < 200; i++) begin
      if (grant[0]) cnt++;
      step();
    end
    check("R6 full weight grants nearly all", int'(cnt >= 199), 1);
    wr_prob = 16'h8000;
    #1;
    cnt = 0;
    for (int i = 0; i < 400; i++) begin
      if (grant[0]) cnt++;
      step();
    end
    check("R6 half weight partial rate", int'(cnt > 100 && cnt < 300), 1);
    acc_valid = '0; acc_write = '0; mode = 2'b00; wr_prob = '0;
  endtask

  task automatic t_predict();
    @(negedge clk);
    mode = 2'b10;
    acc_valid = 4'b0100; acc_write = 4'b0100;
    hq_valid = 1'b1; hq_read = 1'b1; hq_rank = 2'd2;
    #1;
    check("R7 inhibit lags head by one clock", int'(grant), 4);
    step();
    check("R7 inhibit flag set", int'(inhibit), 4);
    check("R7 write to inhibited rank held", int'(grant), 0);
    acc_valid = 4'b1000; acc_write = 4'b1000;
    #1;
    check("R7 other rank write passes", int'(grant), 8);
    acc_valid = 4'b0100; acc_write = 4'b0000;
    #1;
    check("R9 read to inhibited rank passes", int'(grant), 4);
    acc_write = 4'b0100; hq_read = 1'b0;
    #1;
    check("R11 write still held this cycle", int'(grant), 0);
    step();
    check("R8 head write clears inhibit", int'(inhibit), 0);
    check("R11 held write granted", int'(grant), 4);
    mode = 2'b00; hq_read = 1'b1;
    step();
    check("R8 off mode no inhibit", int'(inhibit), 0);
    idle_inputs();
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_round_robin();
    t_busy();
    t_row_bank();
    t_off_modes();
    t_random();
    t_predict();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule